// File: doc/BRIEF.md
# 4:2:2 MCU Sample Sequencer

The sequencer turns one 16-pixel-wide, 8-row region of colour pixels into the four blocks a transform stage expects. It pulls the region from an upstream line buffer, which holds 16 image lines, as two 8x8 tiles, the left tile before the right one. Every pixel it fetches goes into a local 128-entry frame RAM. The luma of each pixel goes out on the sample stream in the same cycle, as block Y1 for the left tile and block Y2 for the right tile. Once both tiles are held locally, the sequencer replays the chroma from the RAM with 4:2:2 horizontal subsampling. It sends all Cb samples and then all Cr samples. It does not read the line buffer while it does this.

The controller has five states. ST_IDLE waits for `start`. ST_LUMA_L streams the left tile, ST_LUMA_R streams the right tile, ST_CB replays blue-difference chroma, and ST_CR replays red-difference chroma. Each transition happens when the 64th sample of the phase is accepted:
- ST_IDLE to ST_LUMA_L on `start`.
- ST_LUMA_L to ST_LUMA_R.
- ST_LUMA_R to ST_CB.
- ST_CB to ST_CR.
- ST_CR back to ST_IDLE, with a `done` pulse.

A deasserted `out_ready` freezes the whole sequence, so backpressure from the transform stage never loses or repeats a sample. The chroma phases take a fixed 128 accepted samples. `stall` marks them so the line-buffer side can tell that no reads will come.

Top module: `mcu_seq422`

## Requirements
- R1: While reset is held, `out_valid`, `lb_rd`, `stall` and `done` are all 0.
- R2: After `start` is seen in idle, the first 64 accepted samples carry tag 0 (Y1). They are the luma of columns 0-7, rows 0-7, in raster order (row 0 column 0 first). Each is fetched at `lb_row`/`lb_col`.
- R3: The next 64 accepted samples carry tag 1 (Y2). They are the luma of columns 8-15 in raster order.
- R4: The next 64 accepted samples carry tag 2 (Cb). Sample 8r+k equals floor((Cb[r][2k] + Cb[r][2k+1]) / 2), computed without overflow for full-scale inputs.
- R5: The last 64 accepted samples carry tag 3 (Cr), formed from Cr in the same way and the same order as R4.
- R6: `stall` is high exactly while chroma samples are offered, and `lb_rd` is never high at the same time. With `out_ready` held high, `stall` lasts 128 cycles.
- R7: `lb_rd` is high only in a cycle where a luma sample is accepted (`out_valid` and `out_ready` both high). It stays low while the sink refuses a luma sample.
- R8: Under arbitrary `out_ready` patterns, a region delivers exactly 256 samples, with none lost or repeated. An offered sample holds its tag and fetch address until it is accepted.
- R9: `done` is high only in the cycle the last Cr sample is accepted. The block then returns to idle with `out_valid` low.
- R10: A `start` raised while a region is in progress is ignored and does not restart or lengthen the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one region (sampled in idle only) |
| lb_rd | output | 1 | Line-buffer read strobe; pixel consumed this cycle |
| lb_row | output | 3 | Row within the region being fetched |
| lb_col | output | 4 | Column within the region being fetched (0-15) |
| lb_y | input | 8 | Luma of the addressed pixel |
| lb_cb | input | 8 | Blue-difference chroma of the addressed pixel |
| lb_cr | input | 8 | Red-difference chroma of the addressed pixel |
| out_valid | output | 1 | Sample offered to the transform stage |
| out_ready | input | 1 | Transform stage accepts the sample |
| out_tag | output | 2 | Component: 0 Y1, 1 Y2, 2 Cb, 3 Cr |
| out_data | output | 8 | Sample value |
| stall | output | 1 | Line buffer is not being read (chroma window) |
| done | output | 1 | Last Cr sample accepted this cycle |

## Verification
Two things can happen in the same cycle: the acceptance that ends a phase (the 64th sample of a tile, or the final Cr sample with its `done`), and a change of `out_ready` or a stray `start`. Random backpressure is applied so that refusals often land on phase boundaries. A `start` pulse is also injected in the middle of a region. Each accepted sample is compared with a value the bench computes from the pixel pattern and the sample's position, so a skipped or repeated boundary sample shows up as a tag or value mismatch. The region must end with exactly 256 samples, `done` on the last one, and then silence.

// File: rtl/mcu_seq_pkg.sv
package mcu_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LUMA_L,
        ST_LUMA_R,
        ST_CB,
        ST_CR
    } seq_state_t;

    localparam logic [1:0] TAG_Y1 = 2'd0;
    localparam logic [1:0] TAG_Y2 = 2'd1;
    localparam logic [1:0] TAG_CB = 2'd2;
    localparam logic [1:0] TAG_CR = 2'd3;

endpackage

// File: rtl/mcu_frame_ram.sv
// Region store: one synchronous write port, two combinational read ports
// so a horizontal pixel pair is available in a single cycle.
module mcu_frame_ram #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/mcu_pair_avg.sv
// Truncated mean of two samples; one guard bit keeps the full-scale sum.
module mcu_pair_avg #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [PIX_W-1:0] avg
);

    logic [PIX_W:0] sum;

    assign sum = {1'b0, a} + {1'b0, b};
    assign avg = sum[PIX_W:1];

endmodule

// File: rtl/mcu_seq422.sv
module mcu_seq422
    import mcu_seq_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int TILE  = 8,
    localparam int REG_W  = 2 * TILE,
    localparam int DEPTH  = REG_W * TILE,
    localparam int IDX_W  = $clog2(TILE * TILE),
    localparam int HALF_W = $clog2(TILE),
    localparam int COL_W  = $clog2(REG_W),
    localparam int ROW_W  = $clog2(TILE),
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WORD_W = 3 * PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             lb_rd,
    output logic [ROW_W-1:0] lb_row,
    output logic [COL_W-1:0] lb_col,
    input  logic [PIX_W-1:0] lb_y,
    input  logic [PIX_W-1:0] lb_cb,
    input  logic [PIX_W-1:0] lb_cr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_tag,
    output logic [PIX_W-1:0] out_data,
    output logic             stall,
    output logic             done
);

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    logic              fire;
    logic              last;
    logic [ROW_W-1:0]  row;
    logic [HALF_W-1:0] col_t;
    logic              luma_ph;
    logic              ram_we;
    logic [ADDR_W-1:0] waddr, raddr_a, raddr_b;
    logic [WORD_W-1:0] wword, rword_a, rword_b;
    logic [PIX_W-1:0]  chroma_avg [2];

    assign row   = idx_q[IDX_W-1:HALF_W];
    assign col_t = idx_q[HALF_W-1:0];
    assign last  = (idx_q == '1);

    // Even/odd neighbours of the current chroma pair, same row.
    assign raddr_a = {row, col_t, 1'b0};
    assign raddr_b = {row, col_t, 1'b1};
    assign waddr   = {row, lb_col};
    assign wword   = {lb_y, lb_cb, lb_cr};

    mcu_frame_ram #(
        .WIDTH (WORD_W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (waddr),
        .wdata   (wword),
        .raddr_a (raddr_a),
        .rdata_a (rword_a),
        .raddr_b (raddr_b),
        .rdata_b (rword_b)
    );

    // g = 0 averages Cb, g = 1 averages Cr.
    for (genvar g = 0; g < 2; g++) begin : g_avg
        mcu_pair_avg #(.PIX_W(PIX_W)) u_avg (
            .a   (rword_a[(2-g)*PIX_W-1 -: PIX_W]),
            .b   (rword_b[(2-g)*PIX_W-1 -: PIX_W]),
            .avg (chroma_avg[g])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LUMA_L;
                    idx_d   = '0;
                end
            end
            ST_LUMA_L: begin
                if (fire) begin
                    idx_d = idx_q + 1'b1;
                    if (last) state_d = ST_LUMA_R;
                end
            end
            ST_LUMA_R: begin
                if (fire) begin
                    idx_d = idx_q + 1'b1;
                    if (last) state_d = ST_CB;
                end
            end
            ST_CB: begin
                if (fire) begin
                    idx_d = idx_q + 1'b1;
                    if (last) state_d = ST_CR;
                end
            end
            ST_CR: begin
                if (fire) begin
                    idx_d = idx_q + 1'b1;
                    if (last) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_tag   = TAG_Y1;
        out_data  = '0;
        luma_ph   = 1'b0;
        stall     = 1'b0;
        lb_row    = '0;
        lb_col    = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_LUMA_L: begin
                out_valid = 1'b1;
                luma_ph   = 1'b1;
                out_tag   = TAG_Y1;
                lb_row    = row;
                lb_col    = COL_W'(col_t);
                out_data  = lb_y;
            end
            ST_LUMA_R: begin
                out_valid = 1'b1;
                luma_ph   = 1'b1;
                out_tag   = TAG_Y2;
                lb_row    = row;
                lb_col    = COL_W'(col_t) + COL_W'(TILE);
                out_data  = lb_y;
            end
            ST_CB: begin
                out_valid = 1'b1;
                stall     = 1'b1;
                out_tag   = TAG_CB;
                out_data  = chroma_avg[0];
            end
            ST_CR: begin
                out_valid = 1'b1;
                stall     = 1'b1;
                out_tag   = TAG_CR;
                out_data  = chroma_avg[1];
            end
            default: begin
            end
        endcase
    end

    assign fire   = out_valid && out_ready;
    assign lb_rd  = luma_ph && out_ready;
    assign ram_we = lb_rd;
    assign done   = (state_q == ST_CR) && fire && last;

endmodule

// File: rtl/mcu_seq422_chk.sv
module mcu_seq422_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lb_rd,
    input logic [2:0] lb_row,
    input logic [3:0] lb_col,
    input logic       out_valid,
    input logic       out_ready,
    input logic [1:0] out_tag,
    input logic       stall,
    input logic       done
);

    // R1: quiet outputs while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!out_valid && !lb_rd && !stall && !done);
        end
    end

    a_r6_stall_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !lb_rd);

    a_r7_read_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        lb_rd |-> (out_valid && out_ready && out_tag <= 2'd1));

    a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_tag) && $stable(lb_row) && $stable(lb_col)));

    a_r2_tag_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_tag >= $past(out_tag)));

    a_r9_done_on_cr: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && out_ready && out_tag == 2'd3));

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !out_valid);

endmodule

bind mcu_seq422 mcu_seq422_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lb_rd     (lb_rd),
    .lb_row    (lb_row),
    .lb_col    (lb_col),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tag   (out_tag),
    .stall     (stall),
    .done      (done)
);

// File: tb/tb_mcu_seq422.sv
module tb_mcu_seq422;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       lb_rd;
    logic [2:0] lb_row;
    logic [3:0] lb_col;
    logic [7:0] lb_y, lb_cb, lb_cr;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [1:0] out_tag;
    logic [7:0] out_data;
    logic       stall;
    logic       done;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int stall_cyc = 0;
    int ready_mode = 0;
    int pat = 0;
    int unsigned salt = 0;
    bit frame_end = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_seq422 dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .lb_rd(lb_rd), .lb_row(lb_row), .lb_col(lb_col),
        .lb_y(lb_y), .lb_cb(lb_cb), .lb_cr(lb_cr),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_data(out_data),
        .stall(stall), .done(done)
    );

    // ch: 0 Y, 1 Cb, 2 Cr
    function automatic int pix(int p, int unsigned s, int ch, int r, int c);
        if (p == 1) return 255;
        if (p == 2) return (ch == 0) ? (r * 16 + c) : (((c + ch) % 2 == 0) ? 255 : 0);
        return int'(((s + ch * 91 + r * 29 + c * 13 + r * c * 7) ^ (s >> 8)) & 8'hFF);
    endfunction

    always_comb begin
        lb_y  = 8'(pix(pat, salt, 0, int'(lb_row), int'(lb_col)));
        lb_cb = 8'(pix(pat, salt, 1, int'(lb_row), int'(lb_col)));
        lb_cr = 8'(pix(pat, salt, 2, int'(lb_row), int'(lb_col)));
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (sample %0d)", req, act, exp, n);
        end
    endtask

    // Stream monitor: drive ready at the falling edge, judge just after.
    always @(negedge clk) begin
        if (ready_mode == 1) out_ready = (($urandom % 10) < 7);
        else out_ready = 1'b1;
        #1;
        if (rst_n) begin
            if (stall) stall_cyc++;
            if (stall && lb_rd) check("R6 read during stall", 1, 0);
            if (out_valid && !out_ready && lb_rd) check("R7 read on refusal", 1, 0);
            if (out_valid && out_ready) begin
                int m, r, c, et, ed, ch;
                m = n % 64;
                r = m / 8;
                c = m % 8;
                if (n < 128) begin
                    et = n / 64;
                    ed = pix(pat, salt, 0, r, c + 8 * et);
                    check(et == 0 ? "R2 tag" : "R3 tag", int'(out_tag), et);
                    check(et == 0 ? "R2 luma" : "R3 luma", int'(out_data), ed);
                    check("R7 lb_rd with luma", int'(lb_rd), 1);
                    check("R6 stall in luma", int'(stall), 0);
                end else if (n < 256) begin
                    et = (n < 192) ? 2 : 3;
                    ch = et - 1;
                    ed = (pix(pat, salt, ch, r, 2 * c) + pix(pat, salt, ch, r, 2 * c + 1)) / 2;
                    check(et == 2 ? "R4 tag" : "R5 tag", int'(out_tag), et);
                    check(et == 2 ? "R4 chroma" : "R5 chroma", int'(out_data), ed);
                    check("R6 stall in chroma", int'(stall), 1);
                end else begin
                    check("R8 extra sample", n, 255);
                end
                check("R9 done timing", int'(done), (n == 255) ? 1 : 0);
                if (done) frame_end = 1;
                n++;
            end else if (done) begin
                check("R9 done without accept", 1, 0);
            end
        end
    end

    task automatic run_frame(int p, int mode, bit inject);
        bit injected = 0;
        pat = p;
        salt = $urandom;
        ready_mode = mode;
        n = 0;
        stall_cyc = 0;
        frame_end = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!frame_end) begin
            @(negedge clk);
            if (inject && !injected && n >= 70) begin
                start = 1'b1;
                injected = 1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        #2;
        check("R8 sample count", n, 256);
        if (mode == 0) check("R6 stall length", stall_cyc, 128);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #2;
            check(inject ? "R10 idle after stray start" : "R9 idle after done", int'(out_valid), 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_4221));
        repeat (3) @(negedge clk);
        #2;
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 lb_rd", int'(lb_rd), 0);
        check("R1 stall", int'(stall), 0);
        check("R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check("R1 idle out_valid", int'(out_valid), 0);

        run_frame(0, 0, 0);
        run_frame(1, 0, 0);
        run_frame(2, 1, 0);
        run_frame(0, 1, 1);
        for (int f = 0; f < 4; f++) run_frame(0, 1, 0);
        run_frame(0, 0, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule